// File: doc/BRIEF.md
# I2C Slave Status and Interrupt-Flag Controller

This block holds the status and interrupt-flag state of a multi-master I2C interface working as a slave. A byte-level bus engine, which is not part of this block, reports events to it. It reports the ninth clock of each byte together with the kind of that byte and the byte value. It reports when the transmit holding register is moved into the output shifter. It also gives strobes for the sampled read/write bit and the sampled acknowledge bit, and a level for the CRC-buffer-full condition.

A CPU reaches three registers through a 2-bit select: an 8-bit status register, a receive holding register and a transmit holding register. A receive interrupt flag and a transmit interrupt flag, gated by an interrupt-enable input, drive one interrupt request.

The receive holding register works as a single-entry buffer that refuses new bytes while it is full. The address-match flag follows only calling addresses and received data bytes. Bytes sent by the slave leave it unchanged.

Top module: `i2c_slv_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x0A, the receive and transmit holding registers read 0x00, and `irq` is 0.
- R2: Status bit positions, MSB first: 7 receive interrupt flag, 6 transmit interrupt flag, 5 address match, 4 slave read/write, 3 received acknowledge, 2 CRC buffer full, 1 transmit buffer empty, 0 receive buffer full. `cpu_sel` selects what `cpu_rdata` returns: 0 gives status, 1 gives the receive holding register, 2 gives the transmit holding register. Bit 4 takes `rw_bit` on `rw_strobe`. Bit 3 takes `ack_bit` on `ack_strobe`. Bit 2 takes `crc_full_in` one cycle later.
- R3: A ninth-clock event for a received data byte (`ev_kind`=0) arriving while the receive buffer is empty loads `rx_byte` into the receive holding register. It sets status bits 0 and 7.
- R4: While status bit 0 is 1, a received byte is dropped and the held byte stays unchanged. Bit 7 is not set again by a dropped byte. A CPU read of the receive holding register (`cpu_rd` with `cpu_sel`=1) clears bit 0.
- R5: A CPU write with `cpu_sel`=2 loads the transmit holding register (also driven on `tx_data_out`) and clears bit 1. An `ev_tx_load` pulse sets bit 1 and bit 6.
- R6: A CPU status write (`cpu_sel`=0) with 0 in bit 7 or bit 6 clears that flag. A 1 written there has no effect.
- R7: While `mod_en` is 0, bits 7 and 6 are 0 from the next cycle on, and events do not set them.
- R8: `irq` is 1 exactly when `irq_en` is 1 and status bit 7 or bit 6 is 1.
- R9: A ninth-clock event for a calling address (`ev_kind`=1) whose upper seven bits equal `slave_addr` sets bit 5 and is loaded into the receive holding register under R3/R4. A non-matching address changes neither.
- R10: When `ext_addr_en` is 1, a calling address matches if its upper seven bits equal `slave_addr` with the least significant bit ignored.
- R11: Bit 5 clears at the ninth-clock event of a received data byte. A transmitted-byte event (`ev_kind`=2) never changes it.
- R12: CPU writes to status bits 5 to 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable |
| irq_en | input | 1 | Interrupt enable |
| ext_addr_en | input | 1 | Match a pair of adjacent addresses |
| slave_addr | input | 7 | Programmed slave address |
| ev_ninth | input | 1 | Ninth-clock event pulse |
| ev_kind | input | 2 | Byte kind: 0 received data, 1 calling address, 2 transmitted data |
| rx_byte | input | 8 | Byte completed at the ninth clock |
| ev_tx_load | input | 1 | Transmit holding register moved to the shifter |
| rw_strobe | input | 1 | Read/write bit sampled |
| rw_bit | input | 1 | Sampled read/write value |
| ack_strobe | input | 1 | Acknowledge sampled |
| ack_bit | input | 1 | Sampled acknowledge value |
| crc_full_in | input | 1 | CRC buffer full level, stored only |
| cpu_sel | input | 2 | Register select |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| tx_data_out | output | 8 | Transmit holding register to the engine |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- a full receive holding register keeps its byte until it is read;
- an empty one takes an offered byte;
- a transfer to the shifter always leaves the transmit buffer empty;
- the flags stay clear while the module is disabled;
- transmitted-byte events never move the address-match flag;
- the interrupt request never rises without its enable.

Only the bench scenarios can show the rest: the exact status values and bit positions, the adjacent-address matching, the write-zero-to-clear rule, and the fact that writes to read-only bits are ignored.

// File: rtl/i2c_slv_status_pkg.sv
package i2c_slv_status_pkg;

   localparam int STAT_W = 8;

   localparam int SB_RXIF  = 7;
   localparam int SB_TXIF  = 6;
   localparam int SB_MATCH = 5;
   localparam int SB_SRW   = 4;
   localparam int SB_RXAK  = 3;
   localparam int SB_CRCBF = 2;
   localparam int SB_TXBE  = 1;
   localparam int SB_RXBF  = 0;

   localparam logic [STAT_W-1:0] STAT_RESET = 8'h0A;

   typedef enum logic [1:0] {
      KIND_RX_DATA = 2'd0,
      KIND_ADDR    = 2'd1,
      KIND_TX_DATA = 2'd2,
      KIND_NONE    = 2'd3
   } byte_kind_e;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_RXHOLD = 2'd1,
      SEL_TXHOLD = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/slv_addr_cmp.sv
module slv_addr_cmp #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic [ADDR_W-1:0] slave_addr,
   input  logic              ext_en,
   input  logic [DATA_W-1:0] byte_in,
   output logic              hit
);
   localparam int CALL_LSB = DATA_W - ADDR_W;

   if (ADDR_W != DATA_W - 1) begin : g_bad_width
      $error("slv_addr_cmp: ADDR_W must be DATA_W-1");
   end

   logic [ADDR_W-1:0] call_addr;
   logic              exact_hit;

   assign call_addr = byte_in[DATA_W-1:CALL_LSB];
   assign exact_hit = (call_addr == slave_addr);

   if (EXT_SUPPORT) begin : g_ext
      logic pair_hit;
      assign pair_hit = (call_addr[ADDR_W-1:1] == slave_addr[ADDR_W-1:1]);
      assign hit      = ext_en ? pair_hit : exact_hit;
   end else begin : g_exact
      logic unused_ext;
      assign unused_ext = ext_en;
      assign hit        = exact_hit;
   end

endmodule

// File: rtl/slv_rx_hold.sv
module slv_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic [DATA_W-1:0] load_data,
   input  logic              rd_clr,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o,
   output logic              load_ok_o
);
   if (DATA_W < 1) begin : g_bad_width
      $error("slv_rx_hold: DATA_W must be positive");
   end

   logic [DATA_W-1:0] data_q;
   logic              full_q;
   logic              load_ok;

   assign load_ok = load_req && !full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         full_q <= 1'b0;
      end else begin
         if (load_ok) data_q <= load_data;
         full_q <= load_ok || (full_q && !rd_clr);
      end
   end

   assign data_o    = data_q;
   assign full_o    = full_q;
   assign load_ok_o = load_ok;

   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |=> $stable(data_q)); // R4
   AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (load_req && !full_q) |=> (full_q && data_q == $past(load_data))); // R3

endmodule

// File: rtl/slv_tx_hold.sv
module slv_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_load,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              xfer,
   output logic [DATA_W-1:0] data_o,
   output logic              empty_o
);
   if (DATA_W < 1) begin : g_bad_width
      $error("slv_tx_hold: DATA_W must be positive");
   end

   logic [DATA_W-1:0] data_q;
   logic              empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         empty_q <= 1'b1;
      end else begin
         if (cpu_load) data_q <= cpu_data;
         if (xfer)          empty_q <= 1'b1;
         else if (cpu_load) empty_q <= 1'b0;
      end
   end

   assign data_o  = data_q;
   assign empty_o = empty_q;

   AST_TXBE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> empty_q); // R5

endmodule

// File: rtl/slv_irq_flags.sv
module slv_irq_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_en,
   input  logic irq_en,
   input  logic rx_set,
   input  logic tx_set,
   input  logic stat_wr,
   input  logic wr_rxif,
   input  logic wr_txif,
   output logic rxif_o,
   output logic txif_o,
   output logic irq_o
);
   logic rxif_q;
   logic txif_q;
   logic rxif_keep;
   logic txif_keep;

   assign rxif_keep = rxif_q && !(stat_wr && !wr_rxif);
   assign txif_keep = txif_q && !(stat_wr && !wr_txif);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxif_q <= 1'b0;
         txif_q <= 1'b0;
      end else begin
         rxif_q <= mod_en && (rx_set || rxif_keep);
         txif_q <= mod_en && (tx_set || txif_keep);
      end
   end

   assign rxif_o = rxif_q;
   assign txif_o = txif_q;
   assign irq_o  = irq_en && (rxif_q || txif_q);

   AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |=> (!rxif_q && !txif_q)); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> irq_en); // R8

endmodule

// File: rtl/i2c_slv_status_ctrl.sv
module i2c_slv_status_ctrl
   import i2c_slv_status_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter bit EXT_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mod_en,
   input  logic              irq_en,
   input  logic              ext_addr_en,
   input  logic [ADDR_W-1:0] slave_addr,
   input  logic              ev_ninth,
   input  logic [1:0]        ev_kind,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              ev_tx_load,
   input  logic              rw_strobe,
   input  logic              rw_bit,
   input  logic              ack_strobe,
   input  logic              ack_bit,
   input  logic              crc_full_in,
   input  logic [1:0]        cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [DATA_W-1:0] tx_data_out,
   output logic              irq
);
   if (DATA_W != STAT_W) begin : g_bad_data_w
      $error("i2c_slv_status_ctrl: DATA_W must equal the status width");
   end
   if (ADDR_W != DATA_W - 1) begin : g_bad_addr_w
      $error("i2c_slv_status_ctrl: ADDR_W must be DATA_W-1");
   end

   logic ninth_rx;
   logic ninth_addr;
   logic ninth_tx;
   logic addr_hit;
   logic addr_taken;
   logic rx_req;
   logic rx_load_ok;
   logic rx_full;
   logic tx_empty;
   logic rxif;
   logic txif;
   logic stat_wr;
   logic tx_wr;
   logic rx_rd;

   logic match_q;
   logic srw_q;
   logic rxak_q;
   logic crc_q;

   logic [DATA_W-1:0] rx_data;
   logic [DATA_W-1:0] tx_data;
   logic [STAT_W-1:0] status;

   assign ninth_rx   = ev_ninth && (ev_kind == KIND_RX_DATA);
   assign ninth_addr = ev_ninth && (ev_kind == KIND_ADDR);
   assign ninth_tx   = ev_ninth && (ev_kind == KIND_TX_DATA);
   assign addr_taken = ninth_addr && addr_hit;
   assign rx_req     = ninth_rx || addr_taken;

   assign stat_wr = cpu_wr && (cpu_sel == SEL_STATUS);
   assign tx_wr   = cpu_wr && (cpu_sel == SEL_TXHOLD);
   assign rx_rd   = cpu_rd && (cpu_sel == SEL_RXHOLD);

   slv_addr_cmp #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .EXT_SUPPORT (EXT_SUPPORT)
   ) u_addr_cmp (
      .slave_addr (slave_addr),
      .ext_en     (ext_addr_en),
      .byte_in    (rx_byte),
      .hit        (addr_hit)
   );

   slv_rx_hold #(.DATA_W(DATA_W)) u_rx_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (rx_req),
      .load_data (rx_byte),
      .rd_clr    (rx_rd),
      .data_o    (rx_data),
      .full_o    (rx_full),
      .load_ok_o (rx_load_ok)
   );

   slv_tx_hold #(.DATA_W(DATA_W)) u_tx_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_load (tx_wr),
      .cpu_data (cpu_wdata),
      .xfer     (ev_tx_load),
      .data_o   (tx_data),
      .empty_o  (tx_empty)
   );

   slv_irq_flags u_irq_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .mod_en  (mod_en),
      .irq_en  (irq_en),
      .rx_set  (rx_load_ok),
      .tx_set  (ev_tx_load),
      .stat_wr (stat_wr),
      .wr_rxif (cpu_wdata[SB_RXIF]),
      .wr_txif (cpu_wdata[SB_TXIF]),
      .rxif_o  (rxif),
      .txif_o  (txif),
      .irq_o   (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= STAT_RESET[SB_MATCH];
         srw_q   <= STAT_RESET[SB_SRW];
         rxak_q  <= STAT_RESET[SB_RXAK];
         crc_q   <= STAT_RESET[SB_CRCBF];
      end else begin
         if (addr_taken)    match_q <= 1'b1;
         else if (ninth_rx) match_q <= 1'b0;
         if (rw_strobe)  srw_q  <= rw_bit;
         if (ack_strobe) rxak_q <= ack_bit;
         crc_q <= crc_full_in;
      end
   end

   always_comb begin
      status           = '0;
      status[SB_RXIF]  = rxif;
      status[SB_TXIF]  = txif;
      status[SB_MATCH] = match_q;
      status[SB_SRW]   = srw_q;
      status[SB_RXAK]  = rxak_q;
      status[SB_CRCBF] = crc_q;
      status[SB_TXBE]  = tx_empty;
      status[SB_RXBF]  = rx_full;
   end

   always_comb begin
      case (cpu_sel)
         SEL_STATUS: cpu_rdata = status;
         SEL_RXHOLD: cpu_rdata = rx_data;
         SEL_TXHOLD: cpu_rdata = tx_data;
         default:    cpu_rdata = '0;
      endcase
   end

   assign tx_data_out = tx_data;

   AST_MATCH_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ninth_tx |=> $stable(match_q)); // R11
   AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
      addr_taken |=> match_q); // R9
   AST_MATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ninth_rx |=> !match_q); // R11

endmodule

// File: tb/test_i2c_slv_status_ctrl.sv
module test_i2c_slv_status_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_en = 1'b0;
   logic       irq_en = 1'b0;
   logic       ext_addr_en = 1'b0;
   logic [6:0] slave_addr = 7'h52;
   logic       ev_ninth = 1'b0;
   logic [1:0] ev_kind = 2'd3;
   logic [7:0] rx_byte = 8'h00;
   logic       ev_tx_load = 1'b0;
   logic       rw_strobe = 1'b0;
   logic       rw_bit = 1'b0;
   logic       ack_strobe = 1'b0;
   logic       ack_bit = 1'b0;
   logic       crc_full_in = 1'b0;
   logic [1:0] cpu_sel = 2'd0;
   logic       cpu_wr = 1'b0;
   logic       cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic [7:0] tx_data_out;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   i2c_slv_status_ctrl i_i2c_slv_status_ctrl (
      .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .irq_en(irq_en),
      .ext_addr_en(ext_addr_en), .slave_addr(slave_addr),
      .ev_ninth(ev_ninth), .ev_kind(ev_kind), .rx_byte(rx_byte),
      .ev_tx_load(ev_tx_load), .rw_strobe(rw_strobe), .rw_bit(rw_bit),
      .ack_strobe(ack_strobe), .ack_bit(ack_bit), .crc_full_in(crc_full_in),
      .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tx_data_out(tx_data_out), .irq(irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input logic [1:0] sel, output logic [7:0] val);
      cpu_sel = sel;
      #1 val = cpu_rdata;
      cpu_sel = 2'd0;
   endtask

   task automatic chk_stat(input string req, input logic [7:0] mask, input logic [7:0] exp);
      logic [7:0] v;
      rd_reg(2'd0, v);
      chk(req, v & mask, exp & mask);
   endtask

   task automatic ninth(input logic [1:0] kind, input logic [7:0] b);
      ev_ninth = 1'b1; ev_kind = kind; rx_byte = b;
      @(negedge clk);
      ev_ninth = 1'b0; ev_kind = 2'd3;
   endtask

   task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
      cpu_sel = sel; cpu_wr = 1'b1; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0; cpu_sel = 2'd0;
   endtask

   task automatic cpu_pop(output logic [7:0] d);
      cpu_sel = 2'd1; cpu_rd = 1'b1;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0; cpu_sel = 2'd0;
   endtask

   task automatic tx_xfer();
      ev_tx_load = 1'b1;
      @(negedge clk);
      ev_tx_load = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk_stat("R1 status", 8'hFF, 8'h0A);
      rd_reg(2'd1, v); chk("R1 rx hold", v, 8'h00);
      rd_reg(2'd2, v); chk("R1 tx hold", v, 8'h00);
      chk("R1 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_rx_buffer();
      logic [7:0] v;
      ninth(2'd0, 8'h5A);
      chk_stat("R3 load sets RXIF/RXBF", 8'hFF, 8'h8B);
      rd_reg(2'd1, v); chk("R3 rx data", v, 8'h5A);
      cpu_write(2'd0, 8'h40);
      chk_stat("R6 write 0 clears RXIF, 1 to TXIF ignored", 8'hFF, 8'h0B);
      ninth(2'd0, 8'hC3);
      rd_reg(2'd1, v); chk("R4 dropped byte keeps held", v, 8'h5A);
      chk_stat("R4 no RXIF on dropped byte", 8'h81, 8'h01);
      cpu_pop(v); chk("R4 pop value", v, 8'h5A);
      chk_stat("R4 read clears RXBF", 8'h01, 8'h00);
      ninth(2'd0, 8'h11);
      rd_reg(2'd1, v); chk("R3 reload after read", v, 8'h11);
      chk_stat("R3 flags after reload", 8'h81, 8'h81);
      cpu_pop(v);
      cpu_write(2'd0, 8'h00);
   endtask

   task automatic t_readonly();
      ninth(2'd0, 8'h22);
      cpu_write(2'd0, 8'h00);
      chk_stat("R12 zeros ignored on RO bits", 8'h3F, 8'h0B);
      cpu_write(2'd0, 8'h34);
      chk_stat("R12 ones ignored on RO bits", 8'h3F, 8'h0B);
      begin logic [7:0] v; cpu_pop(v); end
   endtask

   task automatic t_tx();
      cpu_write(2'd2, 8'hA5);
      chk("R5 tx_data_out", tx_data_out, 8'hA5);
      chk_stat("R5 write clears TXBE", 8'h42, 8'h00);
      tx_xfer();
      chk_stat("R5 xfer sets TXBE/TXIF", 8'h42, 8'h42);
   endtask

   task automatic t_irq();
      irq_en = 1'b0; #1;
      chk("R8 irq off without enable", {7'd0, irq}, 8'h00);
      irq_en = 1'b1; #1;
      chk("R8 irq with TXIF", {7'd0, irq}, 8'h01);
      cpu_write(2'd0, 8'hBF);
      chk("R8 irq after clear", {7'd0, irq}, 8'h00);
      chk_stat("R6 TXIF cleared by 0", 8'hC0, 8'h00);
   endtask

   task automatic t_disable();
      tx_xfer();
      mod_en = 1'b0;
      @(negedge clk);
      chk_stat("R7 disable clears flags", 8'hC0, 8'h00);
      tx_xfer();
      ninth(2'd0, 8'h77);
      chk_stat("R7 no set while disabled", 8'hC0, 8'h00);
      chk("R7 irq low", {7'd0, irq}, 8'h00);
      mod_en = 1'b1;
      begin logic [7:0] v; cpu_pop(v); end
   endtask

   task automatic t_match();
      logic [7:0] v;
      ninth(2'd1, 8'hA6);
      chk_stat("R9 non-match no flag", 8'h21, 8'h00);
      ninth(2'd1, 8'hA4);
      chk_stat("R9 match sets MATCH, loads", 8'h21, 8'h21);
      rd_reg(2'd1, v); chk("R9 address in rx hold", v, 8'hA4);
      ninth(2'd2, 8'h00);
      chk_stat("R11 tx byte keeps MATCH", 8'h20, 8'h20);
      ninth(2'd0, 8'h99);
      chk_stat("R11 rx byte clears MATCH", 8'h20, 8'h00);
      cpu_pop(v);
      ext_addr_en = 1'b1;
      ninth(2'd1, 8'hA7);
      chk_stat("R10 pair address matches", 8'h20, 8'h20);
      ninth(2'd0, 8'h01);
      ninth(2'd1, 8'hA0);
      chk_stat("R10 other address no match", 8'h20, 8'h00);
      ext_addr_en = 1'b0;
      cpu_pop(v);
      cpu_write(2'd0, 8'h00);
   endtask

   task automatic t_fields();
      rw_strobe = 1'b1; rw_bit = 1'b1;
      ack_strobe = 1'b1; ack_bit = 1'b0;
      crc_full_in = 1'b1;
      @(negedge clk);
      rw_strobe = 1'b0; ack_strobe = 1'b0;
      chk_stat("R2 SRW/RXAK/CRCBF positions", 8'h1C, 8'h14);
      crc_full_in = 1'b0;
      ack_strobe = 1'b1; ack_bit = 1'b1;
      @(negedge clk);
      ack_strobe = 1'b0;
      chk_stat("R2 RXAK set, CRCBF follows", 8'h1C, 8'h18);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      mod_en = 1'b1;
      @(negedge clk);
      t_rx_buffer();
      t_readonly();
      t_tx();
      t_irq();
      t_disable();
      t_match();
      t_fields();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule